// File: doc/BRIEF.md
# Two-Candidate Voting Booth Tally Controller

This block runs a single voting booth and keeps a running decimal total for each of two candidates. A voter-present signal tells it the booth is occupied; two candidate buttons, wired from mechanical switches and therefore unrelated to the clock, carry the vote. The block drives an Enter lamp, an Occupied lamp and a door-open command. It keeps one cascaded BCD counter per candidate and copies each counter into a display register once the counter has settled.

A vote counts only when exactly one button is pressed. If both buttons are pressed together, or within one clock of each other after synchronization, neither total moves but the door still opens. After one decision the booth ignores every button until the voter leaves and the controller is idle again. The controller state is held with one-hot-plus-zero encoding, so idle is the all-zero vector.

Top module: `vote_booth_tally`

## Requirements
- R1: After reset and whenever the controller is idle, enter_lamp is 1 and occupied_lamp is 0. While a voter is present, enter_lamp is 0 and occupied_lamp is 1. The two lamps are never both high.
- R2: A rising press of exactly one button while occupied adds one to that candidate's total, leaves the other total unchanged and raises door_open.
- R3: If both buttons are high in the cycle after the first press is seen, whether pressed in the same cycle or one clock apart, neither total changes and door_open still rises.
- R4: Once door_open is high, further presses are ignored until voter_in falls and the controller returns to idle. Each occupancy yields at most one increment.
- R5: Each total is three BCD digits, least significant digit in bits [3:0], then [7:4], then [11:8]. Every nibble stays in 0 to 9 and carries into the next digit after 9.
- R6: The controller state vector is one-hot or all zero, and idle is all zero.
- R7: Each button passes through a two-flop synchronizer and is acted on only at its rising edge. A button already held when the voter enters does not vote until it is released and pressed again.
- R8: At reset both totals are 000. A display total loads only in the cycle after its counter changes and holds its value at all other times.
- R9: A total at 999 stays at 999 when another vote for that candidate arrives.
- R10: If voter_in falls before any press, the controller returns to idle, no total changes and door_open stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| voter_in | input | 1 | Voter present in booth, door closed |
| btn_a | input | 1 | Candidate A button, asynchronous |
| btn_b | input | 1 | Candidate B button, asynchronous |
| enter_lamp | output | 1 | Booth free indicator |
| occupied_lamp | output | 1 | Booth in use indicator |
| door_open | output | 1 | Command to open the door after a decision |
| tally_a | output | 4*DIGITS | BCD display total for candidate A |
| tally_b | output | 4*DIGITS | BCD display total for candidate B |

## Verification
The assertions check on every cycle the properties that hold locally: lamp exclusivity, the legal state encoding, that no increment fires for both candidates, that any increment comes with the door open and happens only once per occupancy, that BCD digits stay in range, that a full total holds, and that the display holds except in the cycle after a load. Only the bench scenarios can show that the totals match the votes cast over many random occupancies. They also show that near-simultaneous presses become ties, that a button held before entry does not vote, and that an early exit leaves the totals untouched.

// File: rtl/vb_pkg.sv
package vb_pkg;
  // one-hot-plus-zero state bit positions; idle is the all-zero vector
  localparam int ST_OCC  = 0;
  localparam int ST_PICK = 1;
  localparam int ST_DOOR = 2;
  localparam int ST_BITS = 3;
  typedef logic [ST_BITS-1:0] state_t;
  localparam state_t ST_IDLE = '0;
  localparam int NCAND = 2;
endpackage

// File: rtl/vb_sync.sv
module vb_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[s] <= '0;
      else     pipe[s] <= pipe[s-1];
    end
  end

  assign lvl = pipe[STAGES-1];
endmodule

// File: rtl/vb_bcd_counter.sv
module vb_bcd_counter #(
  parameter int DIGITS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inc,
  output logic [4*DIGITS-1:0] count
);
  logic [DIGITS-1:0] carry;
  logic [DIGITS-1:0] is9;

  assign carry[0] = inc & ~(&is9);

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    logic [3:0] dig;
    assign is9[i] = (dig == 4'd9);
    always_ff @(posedge clk) begin
      if (rst)           dig <= 4'd0;
      else if (carry[i]) dig <= is9[i] ? 4'd0 : dig + 4'd1;
    end
    if (i < DIGITS - 1) begin : g_carry
      assign carry[i+1] = carry[i] & is9[i];
    end
    assign count[4*i +: 4] = dig;

    assert_digit_range_R5: assert property (@(posedge clk) disable iff (rst)
      dig <= 4'd9);
  end

  assert_saturate_R9: assert property (@(posedge clk) disable iff (rst)
    (inc && (&is9)) |=> $stable(count));
endmodule

// File: rtl/vb_ctrl.sv
module vb_ctrl
  import vb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             vi,
  input  logic [NCAND-1:0] btn,
  output logic             enter_lamp,
  output logic             occupied_lamp,
  output logic             door_open,
  output logic [NCAND-1:0] inc
);
  state_t           state, nxt;
  logic [NCAND-1:0] btn_prev;
  logic             any_rise;

  assign any_rise = |(btn & ~btn_prev);

  always_comb begin
    nxt = ST_IDLE;
    unique case (1'b1)
      state[ST_OCC]:  nxt = !vi ? ST_IDLE : (any_rise ? state_t'(1 << ST_PICK) : state);
      state[ST_PICK]: nxt = state_t'(1 << ST_DOOR);
      state[ST_DOOR]: nxt = vi ? state : ST_IDLE;
      default:        nxt = vi ? state_t'(1 << ST_OCC) : ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      btn_prev      <= '0;
      enter_lamp    <= 1'b1;
      occupied_lamp <= 1'b0;
      door_open     <= 1'b0;
      inc           <= '0;
    end else begin
      state         <= nxt;
      btn_prev      <= btn;
      enter_lamp    <= (nxt == ST_IDLE);
      occupied_lamp <= (nxt != ST_IDLE);
      door_open     <= nxt[ST_DOOR];
      inc[0]        <= state[ST_PICK] & btn[0] & ~btn[1];
      inc[1]        <= state[ST_PICK] & btn[1] & ~btn[0];
    end
  end

  assert_state_code_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(state));
  assert_lamps_excl_R1: assert property (@(posedge clk) disable iff (rst)
    enter_lamp != occupied_lamp);
  assert_no_double_inc_R3: assert property (@(posedge clk) disable iff (rst)
    !(inc[0] && inc[1]));
  assert_inc_opens_door_R2: assert property (@(posedge clk) disable iff (rst)
    (|inc) |-> door_open);
  assert_one_vote_R4: assert property (@(posedge clk) disable iff (rst)
    (|inc) |=> (inc == '0));
endmodule

// File: rtl/vote_booth_tally.sv
module vote_booth_tally
  import vb_pkg::*;
#(
  parameter int DIGITS      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                voter_in,
  input  logic                btn_a,
  input  logic                btn_b,
  output logic                enter_lamp,
  output logic                occupied_lamp,
  output logic                door_open,
  output logic [4*DIGITS-1:0] tally_a,
  output logic [4*DIGITS-1:0] tally_b
);
  localparam int TW = 4 * DIGITS;

  logic [2:0]                 lvl;
  logic [NCAND-1:0]           inc, ld;
  logic [NCAND-1:0][TW-1:0]   cnt, disp;

  vb_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({btn_b, btn_a, voter_in}), .lvl(lvl)
  );

  vb_ctrl u_ctrl (
    .clk(clk), .rst(rst), .vi(lvl[0]), .btn(lvl[2:1]),
    .enter_lamp(enter_lamp), .occupied_lamp(occupied_lamp),
    .door_open(door_open), .inc(inc)
  );

  for (genvar c = 0; c < NCAND; c++) begin : g_cand
    vb_bcd_counter #(.DIGITS(DIGITS)) u_cnt (
      .clk(clk), .rst(rst), .inc(inc[c]), .count(cnt[c])
    );
    // display loads one cycle after the counter edge, never mid-update
    always_ff @(posedge clk) begin
      if (rst) begin
        ld[c]   <= 1'b0;
        disp[c] <= '0;
      end else begin
        ld[c] <= inc[c];
        if (ld[c]) disp[c] <= cnt[c];
      end
    end

    assert_disp_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !ld[c] |=> $stable(disp[c]));
  end

  assign tally_a = disp[0];
  assign tally_b = disp[1];
endmodule

// File: tb/vote_booth_tally_bench.sv
`timescale 1ns/1ps
module vote_booth_tally_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic voter_in = 1'b0, btn_a = 1'b0, btn_b = 1'b0;
  logic enter_lamp, occupied_lamp, door_open;
  logic [11:0] tally_a, tally_b;
  int n_chk = 0, n_fail = 0, exp_a = 0, exp_b = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vote_booth_tally u_vote_booth_tally (
    .clk(clk), .rst(rst), .voter_in(voter_in), .btn_a(btn_a), .btn_b(btn_b),
    .enter_lamp(enter_lamp), .occupied_lamp(occupied_lamp),
    .door_open(door_open), .tally_a(tally_a), .tally_b(tally_b)
  );

  function automatic logic [11:0] to_bcd(int n);
    return {4'(n / 100), 4'((n / 10) % 10), 4'(n % 10)};
  endfunction

  function automatic int bump(int n);
    return (n >= 999) ? 999 : n + 1;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_totals(string req);
    check({req, " tally_a"}, 32'(tally_a), 32'(to_bcd(exp_a)));
    check({req, " tally_b"}, 32'(tally_b), 32'(to_bcd(exp_b)));
  endtask

  // mode: 0 A, 1 B, 2 both same cycle, 3 A then B next clock, 4 leave
  task automatic occupancy(int mode, bit extra);
    voter_in = 1'b1;
    cyc(5);
    check("R1 occupied", {enter_lamp, occupied_lamp}, 2'b01);
    if (mode == 4) begin
      voter_in = 1'b0;
      cyc(5);
      check("R10 door", door_open, 1'b0);
      check("R10 enter", enter_lamp, 1'b1);
      check_totals("R10");
      return;
    end
    if (mode == 0 || mode == 2 || mode == 3) btn_a = 1'b1;
    if (mode == 1 || mode == 2) btn_b = 1'b1;
    if (mode == 3) begin cyc(1); btn_b = 1'b1; end
    cyc(8);
    if (mode == 0) exp_a = bump(exp_a);
    if (mode == 1) exp_b = bump(exp_b);
    check(mode >= 2 ? "R3 door" : "R2 door", door_open, 1'b1);
    check_totals(mode >= 2 ? "R3" : "R2");
    btn_a = 1'b0; btn_b = 1'b0;
    if (extra) begin
      cyc(3); btn_a = 1'b1; cyc(4); btn_a = 1'b0;
      cyc(3); btn_b = 1'b1; cyc(4); btn_b = 1'b0; cyc(6);
      check_totals("R4 extra press");
      check("R4 door held", door_open, 1'b1);
    end
    cyc(2);
    voter_in = 1'b0;
    cyc(5);
    check("R1 idle", {enter_lamp, occupied_lamp, door_open}, 3'b100);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    cyc(4);
    rst = 1'b0;
    cyc(1);
    check("R8 reset totals", {tally_a, tally_b}, 24'd0);
    check("R1 reset lamps", {enter_lamp, occupied_lamp, door_open}, 3'b100);

    occupancy(0, 1'b1);
    occupancy(1, 1'b0);
    occupancy(2, 1'b0);
    occupancy(3, 1'b0);
    occupancy(4, 1'b0);

    // R7: button held from before entry does not vote
    btn_a = 1'b1;
    cyc(4);
    voter_in = 1'b1;
    cyc(10);
    check("R7 held door", door_open, 1'b0);
    check_totals("R7 held");
    btn_a = 1'b0; cyc(3);
    btn_b = 1'b1; cyc(8);
    exp_b = bump(exp_b);
    check("R7 fresh press door", door_open, 1'b1);
    check_totals("R7 fresh press");
    btn_b = 1'b0; voter_in = 1'b0; cyc(5);

    for (int i = 0; i < 150; i++) occupancy(int'($urandom % 5), bit'($urandom % 4 == 0));

    // R5 carry and R9 saturation for candidate A
    while (exp_a < 999) occupancy(0, 1'b0);
    check("R5 nines", 32'(tally_a), 32'h999);
    occupancy(0, 1'b0);
    check("R9 saturate", 32'(tally_a), 32'h999);
    occupancy(1, 1'b0);
    check_totals("R9 other candidate");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule